// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Build-Time Profile

This block gathers up to 32 external interrupt lines for a small processor core. It keeps per-line enable, pending, active and priority state, and it picks the most urgent pending line for the core. A 32-bit register port lets software read and change that state. The core is told the winning line's number and priority, and only when that line may preempt the work already in progress. The core then answers with an activate strobe when it takes the interrupt and a return strobe when it finishes.

A build-time parameter selects one of two profiles that share the same register layout. The full profile keeps 8 priority bits, exposes a type word and active bits, and has a writable priority-grouping field that splits each priority into a preempting group part and a sub-priority. The reduced profile keeps only the top 2 priority bits (four levels). In that profile the type word raises a bus error, the active words read as zero and the grouping field is fixed at zero.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, all enable, pending, active, priority and grouping state is zero, and irq_req, bus_err and bus_rvalid are low.
- R2: Word 0 at 0x100 sets enables and at 0x180 clears them; word 0 at 0x200 sets pending and at 0x280 clears it. A 1 in bit i acts on line i, a 0 does nothing, and reads of either word of a pair return the current state. The other words in each 64-byte range read 0 without error.
- R3: Priority bytes start at 0x400, with line 4k+b in byte b (bits 8b+7..8b) of word 0x400+4k. The full profile keeps all 8 bits. The reduced profile keeps bits 7..6 and stores zero in bits 5..0.
- R4: In the full profile a read of 0x004 returns ceil(lines/32)-1, which is 0 for 32 lines. In the reduced profile any access to 0x004 reads 0 with bus_err.
- R5: Reads in 0x300..0x33F return the active bits (bit i = line i, word 0) in the full profile. In the reduced profile they return 0. Writes there are ignored without error.
- R6: Bits 2..0 of 0x008 hold the grouping field G. It is writable in the full profile. In the reduced profile it reads 0 and writes are ignored.
- R7: The candidate is the pending, enabled, not active line with the numerically lowest priority. Ties go to the lowest line number. irq_num and irq_prio present it one clock after the state that selects it.
- R8: A rising edge on irq_in[i] sets pending[i]. A level held high does not set it again after it has been cleared.
- R9: act_stb while irq_req is high sets active and clears pending for the presented irq_num. ret_stb clears active[ret_num].
- R10: irq_req is high only when a candidate exists and no line is active, or when the candidate's group priority is below the lowest group priority among active lines. The group priority is the priority with bits G..0 cleared.
- R11: An access to any offset outside the implemented ranges (0x008, 0x004 in the full profile, 0x100..0x33F, and the priority words that exist) reads 0 and raises bus_err for the single response cycle.
- R12: Every bus access gets one response cycle with bus_rvalid high on the following clock. Writes return rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_err | output | 1 | Error response for an unimplemented offset |
| bus_rvalid | output | 1 | Response cycle for the previous access |
| irq_in | input | NUM_IRQ | External interrupt lines, rising edge sets pending |
| irq_req | output | 1 | Candidate may preempt |
| irq_num | output | $clog2(NUM_IRQ) | Candidate line number |
| irq_prio | output | 8 | Candidate stored priority |
| act_stb | input | 1 | Core takes the presented interrupt |
| ret_stb | input | 1 | Core finishes interrupt ret_num |
| ret_num | input | $clog2(NUM_IRQ) | Line being returned |

## Verification
The checker watches several things on every cycle. It checks that an error response always carries zero data and that a raised request names a line that was eligible on the cycle before. It checks that no presented priority holds bits the profile discards, that taking an interrupt leaves the line active and not pending, and that the reduced profile never shows active bits. Some behaviour only the bench scenarios can show, because both profiles see the same stimulus: tie-breaking by line number, the suppression of preemption by an active line and by a wide grouping field, and the fact that a held level does not re-pend a line.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int ADDR_W = 12;
  localparam int PRIO_W = 8;

  localparam logic [ADDR_W-1:0] OFS_TYPE  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_GROUP = 12'h008;
  localparam logic [5:0] BLK_SETEN = 6'h04;
  localparam logic [5:0] BLK_CLREN = 6'h06;
  localparam logic [5:0] BLK_SETPD = 6'h08;
  localparam logic [5:0] BLK_CLRPD = 6'h0A;
  localparam logic [5:0] BLK_ACT   = 6'h0C;
  localparam logic [9:0] PRIO_WBASE = 10'h100;

  typedef enum logic [3:0] {
    RS_NONE, RS_TYPE, RS_GROUP, RS_SETEN, RS_CLREN,
    RS_SETPD, RS_CLRPD, RS_ACT, RS_PRIO
  } reg_sel_e;

  function automatic logic [PRIO_W-1:0] group_mask(input logic [2:0] g);
    logic [PRIO_W:0] t;
    t = {(PRIO_W+1){1'b1}} << (int'(g) + 1);
    return t[PRIO_W-1:0];
  endfunction
endpackage

// File: rtl/pic_line_state.sv
module pic_line_state #(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
)(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] en_set,
  input  logic [NUM_IRQ-1:0] en_clr,
  input  logic [NUM_IRQ-1:0] pd_set,
  input  logic [NUM_IRQ-1:0] pd_clr,
  input  logic               take_vld,
  input  logic [IDX_W-1:0]   take_num,
  input  logic               ret_vld,
  input  logic [IDX_W-1:0]   ret_num,
  output logic [NUM_IRQ-1:0] en_q,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic [NUM_IRQ-1:0] act_q
);
  logic [NUM_IRQ-1:0] in_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic take_hit, ret_hit, rise;
    assign take_hit = take_vld && (take_num == IDX_W'(i));
    assign ret_hit  = ret_vld && (ret_num == IDX_W'(i));
    assign rise     = irq_in[i] && !in_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        in_q[i]   <= 1'b0;
        en_q[i]   <= 1'b0;
        pend_q[i] <= 1'b0;
        act_q[i]  <= 1'b0;
      end else begin
        in_q[i]   <= irq_in[i];
        en_q[i]   <= (en_q[i] || en_set[i]) && !en_clr[i];
        pend_q[i] <= (pend_q[i] || rise || pd_set[i]) && !pd_clr[i] && !take_hit;
        act_q[i]  <= take_hit || (act_q[i] && !ret_hit);
      end
    end
  end
endmodule

// File: rtl/pic_prio_bank.sv
module pic_prio_bank #(
  parameter int NUM_IRQ = 32,
  parameter int KEEP_BITS = 8,
  localparam int PWORDS = (NUM_IRQ + 3) / 4,
  localparam int PW_W = (PWORDS > 1) ? $clog2(PWORDS) : 1,
  localparam logic [7:0] KEEP = 8'(8'hFF << (8 - KEEP_BITS))
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_vld,
  input  logic [PW_W-1:0]      wr_idx,
  input  logic [31:0]          wr_data,
  output logic [NUM_IRQ*8-1:0] prio_flat
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        prio_flat[8*i +: 8] <= 8'h00;
      else if (wr_vld && wr_idx == PW_W'(i / 4))
        prio_flat[8*i +: 8] <= wr_data[8*(i % 4) +: 8] & KEEP;
    end
  end
endmodule

// File: rtl/pic_select.sv
module pic_select #(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_IRQ-1:0]   en_q,
  input  logic [NUM_IRQ-1:0]   pend_q,
  input  logic [NUM_IRQ-1:0]   act_q,
  input  logic [NUM_IRQ*8-1:0] prio_flat,
  input  logic [7:0]           gmask,
  output logic                 irq_req,
  output logic [IDX_W-1:0]     irq_num,
  output logic [7:0]           irq_prio
);
  logic             best_ok, run_ok, req_d;
  logic [IDX_W-1:0] best_idx;
  logic [7:0]       best_p, run_p;

  always_comb begin
    best_ok  = 1'b0;
    best_idx = '0;
    best_p   = 8'h00;
    run_ok   = 1'b0;
    run_p    = 8'hFF;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (en_q[i] && pend_q[i] && !act_q[i] &&
          (!best_ok || prio_flat[8*i +: 8] < best_p)) begin
        best_ok  = 1'b1;
        best_idx = IDX_W'(i);
        best_p   = prio_flat[8*i +: 8];
      end
      if (act_q[i] && (!run_ok || (prio_flat[8*i +: 8] & gmask) < run_p)) begin
        run_ok = 1'b1;
        run_p  = prio_flat[8*i +: 8] & gmask;
      end
    end
    req_d = best_ok && (!run_ok || ((best_p & gmask) < run_p));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      irq_num  <= '0;
      irq_prio <= 8'h00;
    end else begin
      irq_req  <= req_d;
      irq_num  <= best_idx;
      irq_prio <= best_p;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter bit MAINLINE = 1'b1,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_err,
  output logic               bus_rvalid,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               irq_req,
  output logic [IDX_W-1:0]   irq_num,
  output logic [7:0]         irq_prio,
  input  logic               act_stb,
  input  logic               ret_stb,
  input  logic [IDX_W-1:0]   ret_num
);
  localparam int KEEP_BITS = MAINLINE ? 8 : 2;
  localparam int PWORDS = (NUM_IRQ + 3) / 4;
  localparam int PW_W = (PWORDS > 1) ? $clog2(PWORDS) : 1;
  localparam logic [31:0] TYPE_VAL = 32'((NUM_IRQ + 31) / 32 - 1);

  reg_sel_e           rs;
  logic               word0, wr_go;
  logic [9:0]         poff;
  logic [2:0]         grp_q;
  logic [31:0]        rv;
  logic [NUM_IRQ-1:0] en_vec, pend_vec, act_vec;
  logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr;
  logic [NUM_IRQ*8-1:0] prio_flat;

  // Address decode
  always_comb begin
    poff  = bus_addr[11:2] - PRIO_WBASE;
    word0 = (bus_addr[5:2] == 4'h0);
    rs    = RS_NONE;
    if (bus_addr == OFS_TYPE)
      rs = MAINLINE ? RS_TYPE : RS_NONE;
    else if (bus_addr == OFS_GROUP)
      rs = RS_GROUP;
    else begin
      case (bus_addr[11:6])
        BLK_SETEN: rs = RS_SETEN;
        BLK_CLREN: rs = RS_CLREN;
        BLK_SETPD: rs = RS_SETPD;
        BLK_CLRPD: rs = RS_CLRPD;
        BLK_ACT:   rs = RS_ACT;
        default: begin
          if (bus_addr[11:2] >= PRIO_WBASE && poff < 10'(PWORDS))
            rs = RS_PRIO;
        end
      endcase
    end
  end

  assign wr_go  = bus_sel && bus_wr;
  assign en_set = (wr_go && rs == RS_SETEN && word0) ? bus_wdata[NUM_IRQ-1:0] : '0;
  assign en_clr = (wr_go && rs == RS_CLREN && word0) ? bus_wdata[NUM_IRQ-1:0] : '0;
  assign pd_set = (wr_go && rs == RS_SETPD && word0) ? bus_wdata[NUM_IRQ-1:0] : '0;
  assign pd_clr = (wr_go && rs == RS_CLRPD && word0) ? bus_wdata[NUM_IRQ-1:0] : '0;

  // Grouping field exists only in the full profile
  if (MAINLINE) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst)
        grp_q <= 3'd0;
      else if (wr_go && rs == RS_GROUP)
        grp_q <= bus_wdata[2:0];
    end
  end else begin : g_nogrp
    assign grp_q = 3'd0;
  end

  pic_line_state #(.NUM_IRQ(NUM_IRQ)) u_state (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
    .take_vld(act_stb && irq_req), .take_num(irq_num),
    .ret_vld(ret_stb), .ret_num(ret_num),
    .en_q(en_vec), .pend_q(pend_vec), .act_q(act_vec)
  );

  pic_prio_bank #(.NUM_IRQ(NUM_IRQ), .KEEP_BITS(KEEP_BITS)) u_prio (
    .clk(clk), .rst(rst),
    .wr_vld(wr_go && rs == RS_PRIO), .wr_idx(poff[PW_W-1:0]),
    .wr_data(bus_wdata), .prio_flat(prio_flat)
  );

  pic_select #(.NUM_IRQ(NUM_IRQ)) u_sel (
    .clk(clk), .rst(rst),
    .en_q(en_vec), .pend_q(pend_vec), .act_q(act_vec),
    .prio_flat(prio_flat), .gmask(group_mask(grp_q)),
    .irq_req(irq_req), .irq_num(irq_num), .irq_prio(irq_prio)
  );

  // Read data mux
  always_comb begin
    rv = 32'h0;
    case (rs)
      RS_TYPE:            rv = TYPE_VAL;
      RS_GROUP:           rv = {29'h0, grp_q};
      RS_SETEN, RS_CLREN: rv = word0 ? 32'(en_vec) : 32'h0;
      RS_SETPD, RS_CLRPD: rv = word0 ? 32'(pend_vec) : 32'h0;
      RS_ACT:             rv = (MAINLINE && word0) ? 32'(act_vec) : 32'h0;
      RS_PRIO: begin
        for (int b = 0; b < 4; b++) begin
          if (int'(poff[PW_W-1:0]) * 4 + b < NUM_IRQ)
            rv[8*b +: 8] = prio_flat[8*(int'(poff[PW_W-1:0]) * 4 + b) +: 8];
        end
      end
      default:            rv = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= 32'h0;
      bus_err    <= 1'b0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_sel;
      bus_err    <= bus_sel && rs == RS_NONE;
      bus_rdata  <= (bus_sel && !bus_wr && rs != RS_NONE) ? rv : 32'h0;
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int NUM_IRQ = 32,
  parameter bit MAINLINE = 1'b1,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
)(
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [11:0]        bus_addr,
  input logic [31:0]        bus_rdata,
  input logic               bus_err,
  input logic               bus_rvalid,
  input logic               irq_req,
  input logic [IDX_W-1:0]   irq_num,
  input logic [7:0]         irq_prio,
  input logic               act_stb,
  input logic [NUM_IRQ-1:0] en_vec,
  input logic [NUM_IRQ-1:0] pend_vec,
  input logic [NUM_IRQ-1:0] act_vec
);
  localparam logic [7:0] DROP = MAINLINE ? 8'h00 : 8'h3F;

  logic [NUM_IRQ-1:0] elig_q;
  logic               act_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      elig_q   <= '0;
      act_rd_q <= 1'b0;
    end else begin
      elig_q   <= en_vec & pend_vec & ~act_vec;
      act_rd_q <= bus_sel && !bus_wr && bus_addr[11:6] == 6'h0C;
    end
  end

  // R11
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rvalid && bus_rdata == 32'h0));

  // R7
  pick_elig_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> elig_q[irq_num]);

  // R3
  prio_keep_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((irq_prio & DROP) == 8'h00));

  // R9
  take_state_chk: assert property (@(posedge clk) disable iff (rst)
    (act_stb && irq_req) |=> (act_vec[$past(irq_num)] && !pend_vec[$past(irq_num)]));

  // R5
  act_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && act_rd_q && !MAINLINE) |-> (bus_rdata == 32'h0));

  // R12
  resp_once_chk: assert property (@(posedge clk) disable iff (rst)
    bus_sel |=> bus_rvalid);
endmodule

bind irq_prio_ctrl pic_chk #(.NUM_IRQ(NUM_IRQ), .MAINLINE(MAINLINE)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .bus_rvalid(bus_rvalid),
  .irq_req(irq_req), .irq_num(irq_num), .irq_prio(irq_prio), .act_stb(act_stb),
  .en_vec(en_vec), .pend_vec(pend_vec), .act_vec(act_vec)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  localparam int N = 32;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] exp_m;
    logic        err_m;
    logic [31:0] exp_b;
    logic        err_b;
    logic [7:0]  req;
  } vec_t;

  // Full profile (m) and reduced profile (b) expectations side by side
  localparam vec_t TBL [19] = '{
    '{1'b1, 12'h100, 32'h000000F0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd2},           // R2 set enables 4..7
    '{1'b0, 12'h100, 32'h0, 32'h000000F0, 1'b0, 32'h000000F0, 1'b0, 8'd2},
    '{1'b1, 12'h180, 32'h00000010, 32'h0, 1'b0, 32'h0, 1'b0, 8'd2},           // R2 clear enable 4
    '{1'b0, 12'h180, 32'h0, 32'h000000E0, 1'b0, 32'h000000E0, 1'b0, 8'd2},
    '{1'b1, 12'h200, 32'h00000001, 32'h0, 1'b0, 32'h0, 1'b0, 8'd2},
    '{1'b0, 12'h280, 32'h0, 32'h00000001, 1'b0, 32'h00000001, 1'b0, 8'd2},
    '{1'b1, 12'h280, 32'h00000001, 32'h0, 1'b0, 32'h0, 1'b0, 8'd2},
    '{1'b0, 12'h200, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd2},
    '{1'b0, 12'h13C, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd2},                  // R2 upper word
    '{1'b1, 12'h400, 32'h8044C3FF, 32'h0, 1'b0, 32'h0, 1'b0, 8'd3},           // R3
    '{1'b0, 12'h400, 32'h0, 32'h8044C3FF, 1'b0, 32'h8040C0C0, 1'b0, 8'd3},
    '{1'b0, 12'h41C, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd3},
    '{1'b0, 12'h004, 32'h0, 32'h0, 1'b0, 32'h0, 1'b1, 8'd4},                  // R4
    '{1'b1, 12'h008, 32'h00000005, 32'h0, 1'b0, 32'h0, 1'b0, 8'd6},           // R6
    '{1'b0, 12'h008, 32'h0, 32'h00000005, 1'b0, 32'h0, 1'b0, 8'd6},
    '{1'b1, 12'h008, 32'h00000000, 32'h0, 1'b0, 32'h0, 1'b0, 8'd6},
    '{1'b0, 12'h300, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd5},                  // R5
    '{1'b0, 12'h800, 32'h0, 32'h0, 1'b1, 32'h0, 1'b1, 8'd11},                 // R11
    '{1'b1, 12'h420, 32'hFFFFFFFF, 32'h0, 1'b1, 32'h0, 1'b1, 8'd11}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [N-1:0]  irq_in = '0;
  logic          act_stb = 1'b0, ret_stb = 1'b0;
  logic [4:0]    ret_num = '0;

  logic [31:0] rd_m, rd_b;
  logic        er_m, er_b, rv_m, rv_b, rq_m, rq_b;
  logic [4:0]  nm_m, nm_b;
  logic [7:0]  pr_m, pr_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.NUM_IRQ(N), .MAINLINE(1'b1)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_m), .bus_err(er_m), .bus_rvalid(rv_m),
    .irq_in(irq_in), .irq_req(rq_m), .irq_num(nm_m), .irq_prio(pr_m),
    .act_stb(act_stb), .ret_stb(ret_stb), .ret_num(ret_num));

  irq_prio_ctrl #(.NUM_IRQ(N), .MAINLINE(1'b0)) uut_b (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_b), .bus_err(er_b), .bus_rvalid(rv_b),
    .irq_in(irq_in), .irq_req(rq_b), .irq_num(nm_b), .irq_prio(pr_b),
    .act_stb(act_stb), .ret_stb(ret_stb), .ret_num(ret_num));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_req m", {31'h0, rq_m}, 32'h0);
    check("R1 irq_req b", {31'h0, rq_b}, 32'h0);
    check("R1 rvalid/err", {28'h0, rv_m, er_m, rv_b, er_b}, 32'h0);
    access(1'b0, 12'h100, 32'h0);
    check("R1 enables m", rd_m, 32'h0);
    check("R12 rvalid", {30'h0, rv_m, rv_b}, 32'h3);
    access(1'b0, 12'h400, 32'h0);
    check("R1 prio b", rd_b, 32'h0);

    // Vector table, both profiles
    for (int k = 0; k < 19; k++) begin
      access(TBL[k].wr, TBL[k].addr, TBL[k].wd);
      check($sformatf("R%0d vec%0d rdata m", TBL[k].req, k), rd_m, TBL[k].exp_m);
      check($sformatf("R%0d vec%0d err m", TBL[k].req, k), {31'h0, er_m}, {31'h0, TBL[k].err_m});
      check($sformatf("R%0d vec%0d rdata b", TBL[k].req, k), rd_b, TBL[k].exp_b);
      check($sformatf("R%0d vec%0d err b", TBL[k].req, k), {31'h0, er_b}, {31'h0, TBL[k].err_b});
    end

    // R7 tie: equal priorities go to the lowest line
    access(1'b1, 12'h180, 32'hFFFFFFFF);
    access(1'b1, 12'h400, 32'h40404040);
    access(1'b1, 12'h100, 32'h0000000F);
    access(1'b1, 12'h200, 32'h0000000F);
    idle(3);
    check("R7 tie req m", {31'h0, rq_m}, 32'h1);
    check("R7 tie num m", {27'h0, nm_m}, 32'h0);
    check("R7 tie num b", {27'h0, nm_b}, 32'h0);
    check("R7 tie prio b", {24'h0, pr_b}, 32'h40);

    // R7 distinct priorities: 0xFF,0xC3,0x44,0x80 (reduced C0,C0,40,80)
    access(1'b1, 12'h400, 32'h8044C3FF);
    idle(3);
    check("R7 num m", {27'h0, nm_m}, 32'h2);
    check("R7 prio m", {24'h0, pr_m}, 32'h44);
    check("R7 num b", {27'h0, nm_b}, 32'h2);
    check("R3 prio b", {24'h0, pr_b}, 32'h40);

    // R9 take line 2
    act_stb = 1'b1;
    idle(1);
    act_stb = 1'b0;
    idle(2);
    access(1'b0, 12'h300, 32'h0);
    check("R5 active m", rd_m, 32'h4);
    check("R5 active b", rd_b, 32'h0);
    access(1'b0, 12'h200, 32'h0);
    check("R9 pending m", rd_m, 32'hB);
    check("R9 pending b", rd_b, 32'hB);
    // R10: line 3 (0x80) may not preempt running 0x44 / 0x40
    check("R10 blocked m", {31'h0, rq_m}, 32'h0);
    check("R10 blocked b", {31'h0, rq_b}, 32'h0);

    // R10: line 1 at 0x10 (reduced 0x00) preempts
    access(1'b1, 12'h400, 32'h804410FF);
    idle(3);
    check("R10 preempt m", {31'h0, rq_m}, 32'h1);
    check("R10 preempt num b", {26'h0, rq_b, nm_b}, 32'h21);
    // R6/R10: grouping 7 leaves no group bits in the full profile
    access(1'b1, 12'h008, 32'h7);
    idle(3);
    check("R10 group7 m", {31'h0, rq_m}, 32'h0);
    check("R6 group ignored b", {31'h0, rq_b}, 32'h1);
    access(1'b1, 12'h008, 32'h0);
    idle(3);
    check("R10 group0 m", {31'h0, rq_m}, 32'h1);

    // R9 return line 2
    ret_num = 5'd2;
    ret_stb = 1'b1;
    idle(1);
    ret_stb = 1'b0;
    access(1'b0, 12'h300, 32'h0);
    check("R9 return m", rd_m, 32'h0);

    // R8 edge-triggered pending
    access(1'b1, 12'h280, 32'hFFFFFFFF);
    access(1'b1, 12'h180, 32'hFFFFFFFF);
    access(1'b1, 12'h100, 32'h00000200);
    irq_in[9] = 1'b1;
    idle(3);
    access(1'b0, 12'h200, 32'h0);
    check("R8 edge m", rd_m, 32'h200);
    check("R8 edge b", rd_b, 32'h200);
    check("R8 req num m", {26'h0, rq_m, nm_m}, 32'h29);
    access(1'b1, 12'h280, 32'h00000200);
    idle(3);
    access(1'b0, 12'h200, 32'h0);
    check("R8 level held m", rd_m, 32'h0);
    check("R8 level req b", {31'h0, rq_b}, 32'h0);
    irq_in[9] = 1'b0;
    idle(2);
    irq_in[9] = 1'b1;
    idle(3);
    access(1'b0, 12'h200, 32'h0);
    check("R8 re-edge b", rd_b, 32'h200);

    finish_run();
  end
endmodule